// File: doc/BRIEF.md
# Parallel-Lane Phase-Rotated Downconversion Mixer

This block takes eight real samples per clock, the consecutive samples of one time-interleaved stream at 1.6 GS/s aggregate, and mixes them down to complex baseband. A receiver uses it to move its band to zero frequency before the filtering and decimation stages that follow.

All eight lanes share one phase accumulator. Lane k adds a phase offset of k times the per-sample increment to that accumulator, so lane k carries the oscillator phase of sample k within the block. After each valid block the accumulator advances by eight increments. Together the lanes form one continuous oscillator, even though no single lane steps once per sample.

Each lane reads its sine and cosine from a quarter-wave table and multiplies its sample by the cosine and by the negated sine, which gives I and Q.

Top module: `nco_mixer`

## Requirements
- R1: A synchronous active-high reset clears the phase accumulator to 0, clears `out_valid`, and sets every lane of `out_i` and `out_q` to 0. The first block accepted after reset uses an accumulator value of 0.
- R2: `out_valid` equals the value of `in_valid` sampled three rising edges earlier. Each accepted block yields exactly one output block, in order.
- R3: For a block accepted with accumulator value A and increment N, lane k uses the 32-bit phase (A + k·N) mod 2^32.
- R4: Each accepted block advances the accumulator by 8·N mod 2^32. A cycle with `in_valid` low leaves the accumulator unchanged.
- R5: Each block uses the `phase_inc` value presented together with it, both for the lane offsets and for the accumulator step. A change of `phase_inc` therefore takes effect exactly at a block boundary.
- R6: The top 10 phase bits p select the oscillator value. The table gives sin = round(32767·sin(2π(p+0.5)/1024)) and the matching cosine, built from a 256-entry quarter-wave table with quadrant folding. The output is correct to within 1 LSB.
- R7: I = round-half-up(x·cos / 2^15) and Q = round-half-up(−x·sin / 2^15), both 16-bit signed. They are exact for full-scale inputs, including x = −32768, with no wraparound.
- R8: Lane k occupies bits [16k+15:16k] of `in_data`, `out_i` and `out_q`. Samples are two's complement.
- R9: While `out_valid` is low, `out_i` and `out_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_inc | input | 32 | Per-sample phase increment (fraction of a full turn, scaled by 2^32) |
| in_valid | input | 1 | Marks `in_data` as a valid block of eight samples |
| in_data | input | 128 | Eight signed 16-bit samples; lane 0 in the low bits is the earliest |
| out_valid | output | 1 | Marks `out_i`/`out_q` as a new result block |
| out_i | output | 128 | Eight signed 16-bit in-phase results |
| out_q | output | 128 | Eight signed 16-bit quadrature results |

## Verification
The checker watches several properties on every cycle. It checks the three-cycle valid latency and the accumulator, which holds during idle cycles and steps by eight increments on each block. It checks that the outputs hold between result blocks and that every looked-up sine/cosine pair lies on the unit circle within rounding. The actual numeric values of I and Q show up only in the bench's scenarios, which compare every lane against a floating-point oscillator. These scenarios cover several things: increments that change from block to block, gaps in the valid stream, quadrant-boundary phases, full-scale negative samples, and a restart of the accumulator after a mid-run reset.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  localparam int SAMPLE_W = 16;

  // Quarter-wave entry i of a table with depth entries, half-step offset.
  function automatic int qtr_sine(input int i, input int depth, input int amp);
    real ang;
    ang = 1.5707963267948966 * (real'(i) + 0.5) / real'(depth);
    return int'($sin(ang) * real'(amp));
  endfunction

  // Q15 multiply with round-half-up; result is x*c/2^(SAMPLE_W-1).
  function automatic logic signed [SAMPLE_W-1:0] scale_q15(
    input logic signed [SAMPLE_W-1:0] x,
    input logic signed [SAMPLE_W-1:0] c
  );
    logic signed [2*SAMPLE_W-1:0] prod;
    prod = x * c;
    prod = prod + ((2*SAMPLE_W)'(1) << (SAMPLE_W - 2));
    return prod[2*SAMPLE_W-2 -: SAMPLE_W];
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int LANES   = 8,
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     blk_fire,
  input  logic [PHASE_W-1:0]       phase_inc,
  output logic [PHASE_W-1:0]       acc_o,
  output logic [LANES*IDX_W-1:0]   lane_idx_o
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] blk_step;
  logic [LANES*IDX_W-1:0] idx_q;

  assign blk_step = PHASE_W'(LANES) * phase_inc;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (blk_fire) acc_q <= acc_q + blk_step;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0] lane_ph;
    assign lane_ph = acc_q + PHASE_W'(k) * phase_inc;
    always_ff @(posedge clk) begin
      if (rst) idx_q[k*IDX_W +: IDX_W] <= '0;
      else if (blk_fire) idx_q[k*IDX_W +: IDX_W] <= lane_ph[PHASE_W-1 -: IDX_W];
    end
  end

  assign acc_o      = acc_q;
  assign lane_idx_o = idx_q;

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
  import nco_mix_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0]          idx,
  output logic signed [SAMPLE_W-1:0] cos_o,
  output logic signed [SAMPLE_W-1:0] sin_o
);

  localparam int FINE_W = IDX_W - 2;
  localparam int DEPTH  = 1 << FINE_W;
  localparam int AMP    = (1 << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] qtab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    localparam logic signed [SAMPLE_W-1:0] ENTRY = SAMPLE_W'(qtr_sine(i, DEPTH, AMP));
    assign qtab[i] = ENTRY;
  end

  logic [1:0]                 quad;
  logic [FINE_W-1:0]          fine;
  logic signed [SAMPLE_W-1:0] near_v, far_v;

  assign quad   = idx[IDX_W-1 -: 2];
  assign fine   = idx[FINE_W-1:0];
  assign near_v = qtab[fine];
  assign far_v  = qtab[~fine];

  always_comb begin
    unique case (quad)
      2'd0: begin sin_o =  near_v; cos_o =  far_v;  end
      2'd1: begin sin_o =  far_v;  cos_o = -near_v; end
      2'd2: begin sin_o = -near_v; cos_o = -far_v;  end
      default: begin sin_o = -far_v; cos_o = near_v; end
    endcase
  end

endmodule

// File: rtl/nco_lane_mixer.sv
module nco_lane_mixer
  import nco_mix_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic signed [SAMPLE_W-1:0] cos_v,
  input  logic signed [SAMPLE_W-1:0] sin_v,
  output logic signed [SAMPLE_W-1:0] i_o,
  output logic signed [SAMPLE_W-1:0] q_o
);

  logic signed [SAMPLE_W-1:0] nsin;
  assign nsin = -sin_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_o <= '0;
      q_o <= '0;
    end else if (en) begin
      i_o <= scale_q15(x, cos_v);
      q_o <= scale_q15(x, nsin);
    end
  end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mix_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PHASE_W-1:0]          phase_inc,
  input  logic                        in_valid,
  input  logic [LANES*SAMPLE_W-1:0]   in_data,
  output logic                        out_valid,
  output logic [LANES*SAMPLE_W-1:0]   out_i,
  output logic [LANES*SAMPLE_W-1:0]   out_q
);

  localparam int BUS_W = LANES * SAMPLE_W;

  logic                   blk_fire;
  logic [PHASE_W-1:0]     acc_now;
  logic [LANES*IDX_W-1:0] s1_idx;
  logic                   s1_valid, s2_valid;
  logic [BUS_W-1:0]       s1_data, s2_data;
  logic [BUS_W-1:0]       s2_cos_bus, s2_sin_bus;

  assign blk_fire = in_valid;

  nco_phase_acc #(.LANES(LANES), .PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .blk_fire  (blk_fire),
    .phase_inc (phase_inc),
    .acc_o     (acc_now),
    .lane_idx_o(s1_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s2_valid  <= 1'b0;
      out_valid <= 1'b0;
      s1_data   <= '0;
      s2_data   <= '0;
    end else begin
      s1_valid  <= blk_fire;
      s2_valid  <= s1_valid;
      out_valid <= s2_valid;
      if (blk_fire) s1_data <= in_data;
      if (s1_valid) s2_data <= s1_data;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [SAMPLE_W-1:0] cos_c, sin_c, i_k, q_k;

    nco_sincos_lut #(.IDX_W(IDX_W)) u_lut (
      .idx  (s1_idx[k*IDX_W +: IDX_W]),
      .cos_o(cos_c),
      .sin_o(sin_c)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s2_cos_bus[k*SAMPLE_W +: SAMPLE_W] <= '0;
        s2_sin_bus[k*SAMPLE_W +: SAMPLE_W] <= '0;
      end else if (s1_valid) begin
        s2_cos_bus[k*SAMPLE_W +: SAMPLE_W] <= cos_c;
        s2_sin_bus[k*SAMPLE_W +: SAMPLE_W] <= sin_c;
      end
    end

    nco_lane_mixer u_mix (
      .clk  (clk),
      .rst  (rst),
      .en   (s2_valid),
      .x    (s2_data[k*SAMPLE_W +: SAMPLE_W]),
      .cos_v(s2_cos_bus[k*SAMPLE_W +: SAMPLE_W]),
      .sin_v(s2_sin_bus[k*SAMPLE_W +: SAMPLE_W]),
      .i_o  (i_k),
      .q_o  (q_k)
    );

    assign out_i[k*SAMPLE_W +: SAMPLE_W] = i_k;
    assign out_q[k*SAMPLE_W +: SAMPLE_W] = q_k;
  end

endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk
  import nco_mix_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int PHASE_W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [PHASE_W-1:0]        phase_inc,
  input logic [PHASE_W-1:0]        acc_now,
  input logic                      s2_valid,
  input logic [LANES*SAMPLE_W-1:0] s2_cos_bus,
  input logic [LANES*SAMPLE_W-1:0] s2_sin_bus,
  input logic                      out_valid,
  input logic [LANES*SAMPLE_W-1:0] out_i,
  input logic [LANES*SAMPLE_W-1:0] out_q
);

  localparam longint AMP  = (64'sd1 << (SAMPLE_W - 1)) - 1;
  localparam longint R2LO = AMP * AMP - 3 * AMP;
  localparam longint R2HI = AMP * AMP + 3 * AMP;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> acc_now == '0);

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    since_rst == 2'd3 |-> out_valid == $past(in_valid, 3));

  a_r4_acc_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$past(in_valid)) |-> $stable(acc_now));

  a_r4_acc_block_step: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(in_valid)) |->
      acc_now == $past(acc_now) + PHASE_W'(LANES) * $past(phase_inc));

  a_r9_output_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> ($stable(out_i) && $stable(out_q)));

  for (genvar k = 0; k < LANES; k++) begin : g_circ
    longint c_v, s_v;
    assign c_v = longint'($signed(s2_cos_bus[k*SAMPLE_W +: SAMPLE_W]));
    assign s_v = longint'($signed(s2_sin_bus[k*SAMPLE_W +: SAMPLE_W]));
    a_r6_unit_circle: assert property (@(posedge clk) disable iff (rst)
      s2_valid |-> (c_v * c_v + s_v * s_v >= R2LO && c_v * c_v + s_v * s_v <= R2HI));
  end

endmodule

bind nco_mixer nco_mixer_chk #(.LANES(LANES), .PHASE_W(PHASE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .phase_inc (phase_inc),
  .acc_now   (acc_now),
  .s2_valid  (s2_valid),
  .s2_cos_bus(s2_cos_bus),
  .s2_sin_bus(s2_sin_bus),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/tb_nco_mixer.sv
module tb_nco_mixer;
  localparam int L  = 8;
  localparam int SW = 16;
  localparam int BW = L * SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   phase_inc = '0;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_data = '0;
  logic          out_valid;
  logic [BW-1:0] out_i, out_q;

  always #4 clk = ~clk;

  nco_mixer dut (
    .clk(clk), .rst(rst), .phase_inc(phase_inc), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_run = 0, n_fail = 0;
  bit [31:0] acc_m = '0;
  logic [BW-1:0] qi[$], qq[$];
  string tag_q[$];
  string cur_tag = "R3";
  logic [2:0] vpipe = '0;
  logic [BW-1:0] last_i = '0, last_q = '0;
  bit mon_en = 1'b0;

  function automatic int rnd(input real r);
    return $rtoi($floor(r + 0.5));
  endfunction

  // Reference oscillator and mixer, computed from the requirements.
  task automatic push_expected(input bit [31:0] inc, input logic [BW-1:0] d);
    logic [BW-1:0] ei, eq;
    for (int k = 0; k < L; k++) begin
      bit [31:0] ph;
      int p, c, s, x;
      real ang;
      ph  = acc_m + 32'(k) * inc;
      p   = int'(ph[31:22]);
      ang = 6.283185307179586 * (real'(p) + 0.5) / 1024.0;
      c   = rnd(32767.0 * $cos(ang));
      s   = rnd(32767.0 * $sin(ang));
      x   = int'($signed(d[k*SW +: SW]));
      ei[k*SW +: SW] = SW'(rnd(real'(x) * real'(c) / 32768.0));
      eq[k*SW +: SW] = SW'(rnd(-real'(x) * real'(s) / 32768.0));
    end
    qi.push_back(ei);
    qq.push_back(eq);
    tag_q.push_back(cur_tag);
    acc_m = acc_m + 32'd8 * inc;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input bit [31:0] inc, input logic [BW-1:0] d);
    @(negedge clk);
    phase_inc = inc;
    in_data   = d;
    in_valid  = 1'b1;
    push_expected(inc, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      phase_inc = $urandom;
      in_data   = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    in_valid = 1'b0;
    qi.delete(); qq.delete(); tag_q.delete();
    acc_m = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(out_i == '0 && out_q == '0, "R1", "outputs zero after reset",
          longint'(out_i[SW-1:0]), 0);
    last_i = out_i; last_q = out_q;
    mon_en = 1'b1;
  endtask

  always @(posedge clk) begin
    if (rst) vpipe <= '0;
    else vpipe <= {vpipe[1:0], in_valid};
  end

  // Output monitor at the falling edge
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (out_valid !== vpipe[2]) begin
        n_fail++;
        $display("FAIL R2 out_valid latency: actual=%0b expected=%0b", out_valid, vpipe[2]);
      end
      if (out_valid) begin
        if (qi.size() == 0) begin
          check(1'b0, "R2", "unexpected output block", 1, 0);
        end else begin
          logic [BW-1:0] ei, eq;
          string tg;
          bit ok;
          int bad_k, act_v, exp_v;
          ei = qi.pop_front(); eq = qq.pop_front(); tg = tag_q.pop_front();
          ok = 1'b1; bad_k = 0; act_v = 0; exp_v = 0;
          for (int k = 0; k < L; k++) begin
            int ai, aq, xi, xq;
            ai = int'($signed(out_i[k*SW +: SW])); xi = int'($signed(ei[k*SW +: SW]));
            aq = int'($signed(out_q[k*SW +: SW])); xq = int'($signed(eq[k*SW +: SW]));
            if (ok && (ai - xi > 1 || xi - ai > 1)) begin
              ok = 1'b0; bad_k = k; act_v = ai; exp_v = xi;
            end
            if (ok && (aq - xq > 1 || xq - aq > 1)) begin
              ok = 1'b0; bad_k = k + 100; act_v = aq; exp_v = xq;
            end
          end
          check(ok, tg, $sformatf("R7 R8 lane result (lane %0d, +100 means Q)", bad_k),
                act_v, exp_v);
        end
      end else begin
        check(out_i == last_i && out_q == last_q, "R9", "hold while not valid",
              longint'(out_i[SW-1:0]), longint'(last_i[SW-1:0]));
      end
      last_i = out_i;
      last_q = out_q;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240505));
    do_reset();

    // R3 R6: zero increment, constant positive samples
    cur_tag = "R3 R6";
    send(32'd0, {L{16'sd16384}});
    send(32'd0, {L{16'sd16384}});
    idle(4);

    // R6: quarter-turn per sample, full-scale negative samples (quadrant edges)
    cur_tag = "R6 R7";
    send(32'h4000_0000, {L{16'h8000}});
    send(32'h8000_0000, {L{16'h8000}});
    send(32'hC000_0000, {L{16'h7FFF}});
    idle(4);

    // R8: distinct sample per lane, sixteenth-turn increment
    cur_tag = "R8";
    send(32'h1000_0000, {16'sd7000, -16'sd6000, 16'sd5000, -16'sd4000,
                         16'sd3000, -16'sd2000, 16'sd1000, -16'sd32768});
    idle(4);

    // R4 R5: increment changes every block, random gaps
    cur_tag = "R4 R5";
    for (int b = 0; b < 300; b++) begin
      send($urandom, {$urandom, $urandom, $urandom, $urandom});
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    // R5: back-to-back blocks with a fixed increment, then one switch
    cur_tag = "R5";
    for (int b = 0; b < 20; b++) send(32'h0123_4567, {$urandom, $urandom, $urandom, $urandom});
    for (int b = 0; b < 20; b++) send(32'hF00D_1234, {$urandom, $urandom, $urandom, $urandom});
    idle(4);

    // R1: reset in the middle of a run restarts the accumulator at 0
    do_reset();
    cur_tag = "R1 R3";
    send(32'h0ABC_DEF1, {L{-16'sd20000}});
    send(32'h0ABC_DEF1, {L{16'sd12345}});
    idle(5);

    // R2: all blocks emerged
    check(qi.size() == 0, "R2", "pending blocks at end", longint'(qi.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule